// File: doc/BRIEF.md
# EX-Stage Operand Forwarding and Load-Use Stall Unit

This block sits beside the execute stage of a five-stage in-order pipeline. For each of the two ALU operands it decides where the operand value should come from. There are three possible sources: the register-file value latched into the ID/EX register, the ALU result currently held in EX/MEM, or the final write-back value held in MEM/WB. When both later stages would write the operand's register, the younger producer (EX/MEM) wins, so a chain of instructions that rewrites one register always sees the latest value.

A result that comes from a load is not ready early enough to be forwarded to the instruction right behind it. The block detects this case and asks the pipeline for a one-cycle stall. The load is in ID/EX, and the consumer is in IF/ID and reads the load's destination. During the stall the pipeline holds the PC and IF/ID and sends one bubble down. One cycle later the loaded value reaches MEM/WB, and the normal MEM/WB forward path supplies it.

A two-state controller shapes the stall request. In state OPEN the request follows the load-use detector. On a detected hazard the controller moves from OPEN to HELD. From HELD it always returns to OPEN on the next edge, and while in HELD the request is masked. This caps every stall at exactly one cycle. Reset puts the controller in OPEN.

Top module: `ex_fwd_unit`

## Requirements
- R1: Each operand select uses 2'b00 for the ID/EX register value, 2'b10 for the EX/MEM result and 2'b01 for the MEM/WB value; 2'b11 never appears.
- R2: An operand selects EX/MEM when the EX/MEM write enable is high, the EX/MEM destination is non-zero and equals that operand's source register.
- R3: An operand selects MEM/WB when the MEM/WB write enable is high, its destination is non-zero and equals the source register, and the R2 condition does not hold for that operand.
- R4: When both EX/MEM and MEM/WB qualify for the same operand, EX/MEM is chosen.
- R5: A destination of register 0 is never forwarded; a source of register 0 always selects 2'b00.
- R6: Operand B applies the same rules as operand A, using its own source register, independently of operand A.
- R7: In state OPEN, the stall request is high exactly when the ID/EX instruction is a load, its destination is non-zero, and the destination equals either IF/ID source register. A matching non-load raises no stall.
- R8: A stall request moves the controller from OPEN to HELD. In HELD the request is low whatever the inputs, and the next edge returns the controller to OPEN.
- R9: While reset is asserted, the stall request is low and the controller is held in OPEN.
- R10: For the chain add r1,r1,r2; sub r1,r1,r3; or r1,r4,r1, each consumer selects its most recent producer. After a load-use stall and its bubble, the consumer selects MEM/WB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the stall controller |
| rst_n | input | 1 | Asynchronous active-low reset |
| ifid_rs | input | RA_W | First source register of the instruction in IF/ID |
| ifid_rt | input | RA_W | Second source register of the instruction in IF/ID |
| idex_rs | input | RA_W | Operand A source register of the instruction in ID/EX |
| idex_rt | input | RA_W | Operand B source register of the instruction in ID/EX |
| idex_rd | input | RA_W | Destination register of the instruction in ID/EX |
| idex_is_load | input | 1 | Instruction in ID/EX is a load |
| exmem_rd | input | RA_W | Destination register held in EX/MEM |
| exmem_wr | input | 1 | EX/MEM instruction writes a register |
| memwb_rd | input | RA_W | Destination register held in MEM/WB |
| memwb_wr | input | 1 | MEM/WB instruction writes a register |
| fwd_a_sel | output | 2 | Operand A source select |
| fwd_b_sel | output | 2 | Operand B source select |
| stall_req | output | 1 | Request to freeze PC and IF/ID and insert one bubble |

## Verification
Both operand selects depend combinationally on the present pipeline-register fields, so they are due in the same cycle as their inputs. The bench drives inputs just after a falling edge and samples one nanosecond later, well before the next rising edge. The stall request is also due in the same cycle. Its masking (R8) shows up only after one rising edge, so the bench samples it again at the following falling edge with the inputs left unchanged. The bench then waits one more edge so the controller is back in OPEN before the next pattern. The select sweep covers every combination for an 8-register configuration. The stall sweep covers every load-flag, destination and source combination.

// File: rtl/ex_fwd_pkg.sv
package ex_fwd_pkg;

    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_MEMWB   = 2'b01,
        SRC_EXMEM   = 2'b10
    } fwd_src_e;

    typedef enum logic {
        HZ_OPEN = 1'b0,
        HZ_HELD = 1'b1
    } hz_state_e;

    localparam int NUM_OPERANDS = 2;

endpackage

// File: rtl/ex_fwd_operand_sel.sv
module ex_fwd_operand_sel
    import ex_fwd_pkg::*;
#(
    parameter int RA_W = 5
) (
    input  logic [RA_W-1:0] src_reg,
    input  logic [RA_W-1:0] near_rd,
    input  logic            near_wr,
    input  logic [RA_W-1:0] far_rd,
    input  logic            far_wr,
    output fwd_src_e        sel
);
    localparam logic [RA_W-1:0] REG_ZERO = '0;

    logic near_hit;
    logic far_hit;

    // A producer qualifies only when it writes a real register that this operand reads.
    always_comb begin
        near_hit = near_wr && (near_rd != REG_ZERO) && (near_rd == src_reg);
        far_hit  = far_wr  && (far_rd  != REG_ZERO) && (far_rd  == src_reg);
    end

    // Younger producer (EX/MEM) takes priority over the older one (MEM/WB).
    always_comb begin
        if (near_hit) begin
            sel = SRC_EXMEM;
        end else if (far_hit) begin
            sel = SRC_MEMWB;
        end else begin
            sel = SRC_REGFILE;
        end
    end

endmodule

// File: rtl/ex_load_use_detect.sv
module ex_load_use_detect #(
    parameter int RA_W = 5
) (
    input  logic            load_in_ex,
    input  logic [RA_W-1:0] load_rd,
    input  logic [RA_W-1:0] next_rs,
    input  logic [RA_W-1:0] next_rt,
    output logic            hazard
);
    localparam logic [RA_W-1:0] REG_ZERO = '0;

    logic rs_dep;
    logic rt_dep;

    always_comb begin
        rs_dep = (load_rd == next_rs);
        rt_dep = (load_rd == next_rt);
        hazard = load_in_ex && (load_rd != REG_ZERO) && (rs_dep || rt_dep);
    end

endmodule

// File: rtl/ex_stall_ctrl.sv
module ex_stall_ctrl
    import ex_fwd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hazard,
    output logic stall
);
    hz_state_e state_q;
    hz_state_e state_d;

    // Next-state logic: OPEN -> HELD on a hazard, HELD -> OPEN always.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HZ_OPEN: if (hazard) state_d = HZ_HELD;
            HZ_HELD: state_d = HZ_OPEN;
            default: state_d = HZ_OPEN;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HZ_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    // Output logic.
    always_comb begin
        stall = 1'b0;
        unique case (state_q)
            HZ_OPEN: stall = hazard && rst_n;
            HZ_HELD: stall = 1'b0;
            default: stall = 1'b0;
        endcase
    end

endmodule

// File: rtl/ex_fwd_unit.sv
module ex_fwd_unit
    import ex_fwd_pkg::*;
#(
    parameter int RA_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RA_W-1:0] ifid_rs,
    input  logic [RA_W-1:0] ifid_rt,
    input  logic [RA_W-1:0] idex_rs,
    input  logic [RA_W-1:0] idex_rt,
    input  logic [RA_W-1:0] idex_rd,
    input  logic            idex_is_load,
    input  logic [RA_W-1:0] exmem_rd,
    input  logic            exmem_wr,
    input  logic [RA_W-1:0] memwb_rd,
    input  logic            memwb_wr,
    output logic [1:0]      fwd_a_sel,
    output logic [1:0]      fwd_b_sel,
    output logic            stall_req
);
    logic [RA_W-1:0] op_src [NUM_OPERANDS];
    fwd_src_e        op_sel [NUM_OPERANDS];
    logic            lu_hazard;

    always_comb begin
        op_src[0] = idex_rs;
        op_src[1] = idex_rt;
    end

    for (genvar g = 0; g < NUM_OPERANDS; g++) begin : g_operand
        ex_fwd_operand_sel #(.RA_W(RA_W)) u_sel (
            .src_reg (op_src[g]),
            .near_rd (exmem_rd),
            .near_wr (exmem_wr),
            .far_rd  (memwb_rd),
            .far_wr  (memwb_wr),
            .sel     (op_sel[g])
        );
    end

    assign fwd_a_sel = op_sel[0];
    assign fwd_b_sel = op_sel[1];

    ex_load_use_detect #(.RA_W(RA_W)) u_detect (
        .load_in_ex (idex_is_load),
        .load_rd    (idex_rd),
        .next_rs    (ifid_rs),
        .next_rt    (ifid_rt),
        .hazard     (lu_hazard)
    );

    ex_stall_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .hazard (lu_hazard),
        .stall  (stall_req)
    );

endmodule

// File: rtl/ex_fwd_unit_chk.sv
module ex_fwd_unit_chk #(
    parameter int RA_W = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic [RA_W-1:0] ifid_rs,
    input logic [RA_W-1:0] ifid_rt,
    input logic [RA_W-1:0] idex_rs,
    input logic [RA_W-1:0] idex_rt,
    input logic [RA_W-1:0] idex_rd,
    input logic            idex_is_load,
    input logic [RA_W-1:0] exmem_rd,
    input logic            exmem_wr,
    input logic [RA_W-1:0] memwb_rd,
    input logic            memwb_wr,
    input logic [1:0]      fwd_a_sel,
    input logic [1:0]      fwd_b_sel,
    input logic            stall_req
);
    localparam logic [RA_W-1:0] ZR = '0;

    p_sel_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a_sel != 2'b11) && (fwd_b_sel != 2'b11));

    p_near_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (exmem_wr && exmem_rd != ZR && exmem_rd == idex_rs) |-> (fwd_a_sel == 2'b10));

    p_far_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a_sel == 2'b01) |-> (memwb_wr && memwb_rd == idex_rs && memwb_rd != ZR));

    p_zero_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (idex_rt == ZR) |-> (fwd_b_sel == 2'b00));

    p_stall_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |-> (idex_is_load && idex_rd != ZR &&
                       (idex_rd == ifid_rs || idex_rd == ifid_rt)));

    p_stall_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |=> !stall_req);

endmodule

bind ex_fwd_unit ex_fwd_unit_chk #(.RA_W(RA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ifid_rs      (ifid_rs),
    .ifid_rt      (ifid_rt),
    .idex_rs      (idex_rs),
    .idex_rt      (idex_rt),
    .idex_rd      (idex_rd),
    .idex_is_load (idex_is_load),
    .exmem_rd     (exmem_rd),
    .exmem_wr     (exmem_wr),
    .memwb_rd     (memwb_rd),
    .memwb_wr     (memwb_wr),
    .fwd_a_sel    (fwd_a_sel),
    .fwd_b_sel    (fwd_b_sel),
    .stall_req    (stall_req)
);

// File: tb/ex_fwd_unit_test.sv
module ex_fwd_unit_test;
    localparam int RW = 3;
    localparam int NR = 1 << RW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [RW-1:0] ifid_rs = '0, ifid_rt = '0;
    logic [RW-1:0] idex_rs = '0, idex_rt = '0, idex_rd = '0;
    logic          idex_is_load = 1'b0;
    logic [RW-1:0] exmem_rd = '0, memwb_rd = '0;
    logic          exmem_wr = 1'b0, memwb_wr = 1'b0;
    logic [1:0]    fwd_a_sel, fwd_b_sel;
    logic          stall_req;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    ex_fwd_unit #(.RA_W(RW)) uut (
        .clk(clk), .rst_n(rst_n),
        .ifid_rs(ifid_rs), .ifid_rt(ifid_rt),
        .idex_rs(idex_rs), .idex_rt(idex_rt), .idex_rd(idex_rd),
        .idex_is_load(idex_is_load),
        .exmem_rd(exmem_rd), .exmem_wr(exmem_wr),
        .memwb_rd(memwb_rd), .memwb_wr(memwb_wr),
        .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
        .stall_req(stall_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_sel(int src, int erd, int ewe, int wrd, int wwe);
        if (ewe != 0 && erd != 0 && erd == src) return 2;
        if (wwe != 0 && wrd != 0 && wrd == src) return 1;
        return 0;
    endfunction

    function automatic string sel_tag(int src, int erd, int ewe, int wrd, int wwe);
        bit nh = (ewe != 0 && erd == src);
        bit fh = (wwe != 0 && wrd == src);
        if (src == 0 && (nh || fh)) return "R5";
        if (nh && fh) return "R4";
        if (nh) return "R2";
        if (fh) return "R3";
        return "R1";
    endfunction

    initial begin
        #5000000;
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R9: reset holds stall low even with a load-use pattern present
        idex_is_load = 1'b1; idex_rd = 3'd4; ifid_rs = 3'd4; ifid_rt = 3'd1;
        repeat (2) @(negedge clk);
        #1 chk("R9 stall during reset", stall_req, 0);
        chk("R1 reset select A", fwd_a_sel, 0);
        idex_is_load = 1'b0; idex_rd = '0; ifid_rs = '0; ifid_rt = '0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        #1 chk("R9 stall after reset idle", stall_req, 0);

        // Exhaustive select sweep, no load in EX so the controller stays OPEN
        for (int a = 0; a < NR; a++)
            for (int b = 0; b < NR; b++)
                for (int er = 0; er < NR; er++)
                    for (int ew = 0; ew < 2; ew++)
                        for (int wr = 0; wr < NR; wr++)
                            for (int ww = 0; ww < 2; ww++) begin
                                idex_rs = a[RW-1:0]; idex_rt = b[RW-1:0];
                                exmem_rd = er[RW-1:0]; exmem_wr = ew[0];
                                memwb_rd = wr[RW-1:0]; memwb_wr = ww[0];
                                #1;
                                chk({sel_tag(a, er, ew, wr, ww), " operand A"},
                                    fwd_a_sel, exp_sel(a, er, ew, wr, ww));
                                chk({sel_tag(b, er, ew, wr, ww), " R6 operand B"},
                                    fwd_b_sel, exp_sel(b, er, ew, wr, ww));
                            end
        exmem_wr = 1'b0; memwb_wr = 1'b0; exmem_rd = '0; memwb_rd = '0;

        // Exhaustive stall sweep with R8 masking check
        for (int ld = 0; ld < 2; ld++)
            for (int rd = 0; rd < NR; rd++)
                for (int s = 0; s < NR; s++)
                    for (int t = 0; t < NR; t++) begin
                        int e;
                        @(negedge clk);
                        idex_is_load = ld[0]; idex_rd = rd[RW-1:0];
                        ifid_rs = s[RW-1:0]; ifid_rt = t[RW-1:0];
                        e = (ld != 0 && rd != 0 && (rd == s || rd == t)) ? 1 : 0;
                        #1 chk("R7 stall request", stall_req, e);
                        if (e != 0) begin
                            @(negedge clk);
                            #1 chk("R8 stall masked in HELD", stall_req, 0);
                        end
                    end
        @(negedge clk);
        idex_is_load = 1'b0; idex_rd = '0; ifid_rs = '0; ifid_rt = '0;

        // R10: chain add r1,r1,r2; sub r1,r1,r3; or r1,r4,r1
        @(negedge clk);
        idex_rs = 3'd1; idex_rt = 3'd3; exmem_rd = 3'd1; exmem_wr = 1'b1;
        memwb_rd = 3'd0; memwb_wr = 1'b0;
        #1 chk("R10 sub operand A from add", fwd_a_sel, 2);
        chk("R10 sub operand B regfile", fwd_b_sel, 0);
        @(negedge clk);
        idex_rs = 3'd4; idex_rt = 3'd1; exmem_rd = 3'd1; exmem_wr = 1'b1;
        memwb_rd = 3'd1; memwb_wr = 1'b1;
        #1 chk("R10 or operand B from sub", fwd_b_sel, 2);
        chk("R10 or operand A regfile", fwd_a_sel, 0);

        // R10: lw r4; sub r6,r4,r1 -> stall, bubble, then MEM/WB forward
        @(negedge clk);
        exmem_wr = 1'b0; exmem_rd = '0; memwb_wr = 1'b0; memwb_rd = '0;
        idex_is_load = 1'b1; idex_rd = 3'd4; idex_rs = 3'd2; idex_rt = 3'd0;
        ifid_rs = 3'd4; ifid_rt = 3'd1;
        #1 chk("R10 load-use stall", stall_req, 1);
        @(negedge clk);
        idex_is_load = 1'b0; idex_rd = '0; idex_rs = '0; idex_rt = '0;
        exmem_rd = 3'd4; exmem_wr = 1'b1;
        #1 chk("R10 bubble cycle no stall", stall_req, 0);
        @(negedge clk);
        idex_rs = 3'd4; idex_rt = 3'd1; ifid_rs = '0; ifid_rt = '0;
        exmem_rd = 3'd0; exmem_wr = 1'b0; memwb_rd = 3'd4; memwb_wr = 1'b1;
        #1 chk("R10 consumer A from MEM/WB", fwd_a_sel, 1);
        chk("R10 consumer B regfile", fwd_b_sel, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule